// File: doc/BRIEF.md
# Operand Address Generator with Pointer Registers

This block sits beside the decode stage of a small 8-bit controller and works out, for every issued instruction, which data-memory location the operand lives at. It owns three pointers: the general pointer B, the second pointer X and the stack pointer SP. It also owns a one-shot override address. That override lets an instruction that normally reads through B reach any absolute location instead.

The core presents the opcode, the byte that follows it and, for register-file decrements, the value read from memory. In the same cycle the block returns the operand address, the value to write back for register-form instructions and any skip request. Pointer changes appear after the next rising edge. The core marks an instruction that it is skipping. Such an instruction produces no address and no skip, leaves every pointer alone and consumes any pending override.

Top module: `opaddr_gen`

## Requirements
- R1: After reset B and X read 0x00, SP reads 0x6F, prefix_o is low, and addr_vld_o and skip_o are low.
- R2: The plain B-indirect opcodes (0x68–0x7F, 0x80–0x87, 0x9E, 0xA6, 0xAE, 0xB9) address B. The post-increment opcodes 0x9A, 0xA2 and 0xAA, and the post-decrement opcodes 0x9B, 0xA3 and 0xAB, address the current B and then step B by one.
- R3: Opcodes 0xB6 and 0xBE address X. Opcodes 0xB2 and 0xBA address X and then increment it. Opcodes 0xB3 and 0xBB address X and then decrement it.
- R4: Opcodes 0x9C, 0x9D, 0xA9 and 0xBC use the following byte as the operand address.
- R5: Opcode 0xBD issues no address, stores the following byte and raises prefix_o from the next cycle. The next B-indirect operand, plain or stepping, uses the stored byte as its address and leaves B unchanged.
- R6: A pending override is dropped after exactly one following instruction, whatever that instruction is. A later B-indirect operand uses B again.
- R7: Opcode 0x5k loads B with 15 − k, zero-extended. Opcode 0x9F loads B with the following byte. Neither issues an address.
- R8: Opcode 0x4k raises skip_o when B[3:0] equals k.
- R9: Opcode 0xDr addresses 0xF0 + r and drives the following byte on reg_wdata_o. When r is 12, 13 or 14, X, SP or B respectively takes that byte.
- R10: Opcode 0xCr addresses 0xF0 + r and drives the register value minus one on reg_wdata_o. It raises skip_o when that result is zero. For r = 12, 13 and 14 the value is taken from X, SP or B and that pointer is updated; otherwise the value is mem_rdata_i.
- R11: Opcode 0x67 addresses SP and then decrements it. Opcode 0x8C increments SP and addresses the new value.
- R12: Every pointer step wraps within 8 bits.
- R13: An instruction issued with instr_kill_i high gives no address and no skip, and changes no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_vld_i | input | 1 | An instruction is issued this cycle |
| instr_kill_i | input | 1 | The issued instruction is being skipped |
| opcode_i | input | 8 | First instruction byte |
| opbyte_i | input | 8 | Second instruction byte |
| mem_rdata_i | input | 8 | Register value read from memory for decrement-and-skip |
| addr_o | output | 8 | Operand address |
| addr_vld_o | output | 1 | addr_o carries a valid address |
| reg_wdata_o | output | 8 | Write-back value for register-form instructions |
| b_ptr_o | output | 8 | Current B pointer |
| x_ptr_o | output | 8 | Current X pointer |
| sp_ptr_o | output | 8 | Current stack pointer |
| prefix_o | output | 1 | Address override pending |
| skip_o | output | 1 | Skip-next request |

## Verification
Address, write-back value and skip request are combinational, so they are due in the same cycle that an instruction is issued. Pointer and override changes are due one rising edge later. The bench drives each instruction on the falling edge and samples the combinational results 1 ns afterwards. It then confirms the pointer effects through the address of the following instruction, or through the pointer ports at the next falling edge, so that every sample lands in the cycle its result is due.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

  // Operand addressing mode selected by the decoder
  typedef enum logic [3:0] {
    AM_NONE,
    AM_B,
    AM_BINC,
    AM_BDEC,
    AM_X,
    AM_XINC,
    AM_XDEC,
    AM_ABS,
    AM_PUSH,
    AM_POP,
    AM_REG
  } amode_e;

  // Side action of the instruction on pointers and skip
  typedef enum logic [2:0] {
    OK_PLAIN,
    OK_PREFIX,
    OK_LDB4,
    OK_LDB8,
    OK_BTEST,
    OK_LDREG,
    OK_DECSKIP
  } okind_e;

  typedef struct packed {
    amode_e mode;
    okind_e kind;
  } dec_t;

endpackage

// File: rtl/opaddr_decode.sv
module opaddr_decode
  import opaddr_pkg::*;
(
  input  logic [7:0] opcode_i,
  output dec_t       dec_o
);

  always_comb begin
    dec_o.mode = AM_NONE;
    dec_o.kind = OK_PLAIN;
    casez (opcode_i)
      8'b0100_????: dec_o.kind = OK_BTEST;
      8'b0101_????: dec_o.kind = OK_LDB4;
      8'b0110_0111: dec_o.mode = AM_PUSH;
      8'b0110_1???: dec_o.mode = AM_B;
      8'b0111_????: dec_o.mode = AM_B;
      8'b1000_0???: dec_o.mode = AM_B;
      8'b1000_1100: dec_o.mode = AM_POP;
      8'h9A, 8'hA2, 8'hAA: dec_o.mode = AM_BINC;
      8'h9B, 8'hA3, 8'hAB: dec_o.mode = AM_BDEC;
      8'h9E, 8'hA6, 8'hAE, 8'hB9: dec_o.mode = AM_B;
      8'h9F: dec_o.kind = OK_LDB8;
      8'h9C, 8'h9D, 8'hA9, 8'hBC: dec_o.mode = AM_ABS;
      8'hB2, 8'hBA: dec_o.mode = AM_XINC;
      8'hB3, 8'hBB: dec_o.mode = AM_XDEC;
      8'hB6, 8'hBE: dec_o.mode = AM_X;
      8'hBD: dec_o.kind = OK_PREFIX;
      8'b1100_????: begin
        dec_o.mode = AM_REG;
        dec_o.kind = OK_DECSKIP;
      end
      8'b1101_????: begin
        dec_o.mode = AM_REG;
        dec_o.kind = OK_LDREG;
      end
      default: begin
        dec_o.mode = AM_NONE;
        dec_o.kind = OK_PLAIN;
      end
    endcase
  end

endmodule

// File: rtl/opaddr_ptrs.sv
module opaddr_ptrs
  import opaddr_pkg::*;
#(
  parameter int          DW     = 8,
  parameter int          X_IDX  = 12,
  parameter int          SP_IDX = 13,
  parameter int          B_IDX  = 14,
  parameter logic [DW-1:0] B_RST  = '0,
  parameter logic [DW-1:0] X_RST  = '0,
  parameter logic [DW-1:0] SP_RST = DW'(8'h6F)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic          kill_i,
  input  dec_t          dec_i,
  input  logic [3:0]    nib_i,
  input  logic [DW-1:0] opbyte_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] b_o,
  output logic [DW-1:0] x_o,
  output logic [DW-1:0] sp_o,
  output logic          pend_o,
  output logic [DW-1:0] paddr_o
);

  localparam int PAD_W = DW - 4;

  logic [DW-1:0] b_q, b_d, x_q, x_d, sp_q, sp_d, paddr_q, paddr_d;
  logic          pend_q, pend_d;
  logic          fire;
  logic          reg_wr;

  assign fire   = vld_i && !kill_i;
  assign reg_wr = fire && (dec_i.kind == OK_LDREG || dec_i.kind == OK_DECSKIP);

  // Next-state logic
  always_comb begin
    b_d     = b_q;
    x_d     = x_q;
    sp_d    = sp_q;
    pend_d  = pend_q;
    paddr_d = paddr_q;
    if (fire) begin
      case (dec_i.mode)
        AM_BINC: if (!pend_q) b_d = b_q + 1'b1;
        AM_BDEC: if (!pend_q) b_d = b_q - 1'b1;
        AM_XINC: x_d  = x_q + 1'b1;
        AM_XDEC: x_d  = x_q - 1'b1;
        AM_PUSH: sp_d = sp_q - 1'b1;
        AM_POP:  sp_d = sp_q + 1'b1;
        default: ;
      endcase
      case (dec_i.kind)
        OK_LDB4: b_d = {{PAD_W{1'b0}}, 4'hF - nib_i};
        OK_LDB8: b_d = opbyte_i;
        default: ;
      endcase
    end
    if (reg_wr) begin
      if (int'(nib_i) == B_IDX)  b_d  = wdata_i;
      if (int'(nib_i) == X_IDX)  x_d  = wdata_i;
      if (int'(nib_i) == SP_IDX) sp_d = wdata_i;
    end
    if (vld_i) begin
      if (fire && dec_i.kind == OK_PREFIX) begin
        pend_d  = 1'b1;
        paddr_d = opbyte_i;
      end else begin
        pend_d  = 1'b0;
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q     <= B_RST;
      x_q     <= X_RST;
      sp_q    <= SP_RST;
      pend_q  <= 1'b0;
      paddr_q <= '0;
    end else begin
      b_q     <= b_d;
      x_q     <= x_d;
      sp_q    <= sp_d;
      pend_q  <= pend_d;
      paddr_q <= paddr_d;
    end
  end

  assign b_o     = b_q;
  assign x_o     = x_q;
  assign sp_o    = sp_q;
  assign pend_o  = pend_q;
  assign paddr_o = paddr_q;

  assert_binc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && dec_i.mode == AM_BINC && !pend_q |=> (b_q - $past(b_q)) == DW'(1));

  assert_xdec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && dec_i.mode == AM_XDEC |=> ($past(x_q) - x_q) == DW'(1));

  assert_prefix_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && pend_q && (dec_i.mode == AM_BINC || dec_i.mode == AM_BDEC) |=> $stable(b_q));

  assert_prefix_oneshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i && pend_q && !(fire && dec_i.kind == OK_PREFIX) |=> !pend_q);

  assert_ldb4_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire && dec_i.kind == OK_LDB4 |=> b_q == {{PAD_W{1'b0}}, 4'hF - $past(nib_i)});

  assert_push_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fire && dec_i.mode == AM_PUSH |=> ($past(sp_q) - sp_q) == DW'(1));

  assert_kill_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i && kill_i |=> $stable(b_q) && $stable(x_q) && $stable(sp_q));

endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
  import opaddr_pkg::*;
#(
  parameter int          DW       = 8,
  parameter logic [DW-5:0] REG_PAGE = '1,
  parameter int          X_IDX    = 12,
  parameter int          SP_IDX   = 13,
  parameter int          B_IDX    = 14,
  parameter logic [DW-1:0] B_RST    = '0,
  parameter logic [DW-1:0] X_RST    = '0,
  parameter logic [DW-1:0] SP_RST   = DW'(8'h6F)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_vld_i,
  input  logic          instr_kill_i,
  input  logic [7:0]    opcode_i,
  input  logic [DW-1:0] opbyte_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] addr_o,
  output logic          addr_vld_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic [DW-1:0] b_ptr_o,
  output logic [DW-1:0] x_ptr_o,
  output logic [DW-1:0] sp_ptr_o,
  output logic          prefix_o,
  output logic          skip_o
);

  dec_t          dec;
  logic [3:0]    nib;
  logic          fire;
  logic [DW-1:0] b_q, x_q, sp_q, paddr_q;
  logic          pend_q;
  logic [DW-1:0] reg_val;
  logic [DW-1:0] wdata;

  assign nib  = opcode_i[3:0];
  assign fire = instr_vld_i && !instr_kill_i;

  opaddr_decode u_dec (
    .opcode_i (opcode_i),
    .dec_o    (dec)
  );

  opaddr_ptrs #(
    .DW     (DW),
    .X_IDX  (X_IDX),
    .SP_IDX (SP_IDX),
    .B_IDX  (B_IDX),
    .B_RST  (B_RST),
    .X_RST  (X_RST),
    .SP_RST (SP_RST)
  ) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_n),
    .vld_i    (instr_vld_i),
    .kill_i   (instr_kill_i),
    .dec_i    (dec),
    .nib_i    (nib),
    .opbyte_i (opbyte_i),
    .wdata_i  (wdata),
    .b_o      (b_q),
    .x_o      (x_q),
    .sp_o     (sp_q),
    .pend_o   (pend_q),
    .paddr_o  (paddr_q)
  );

  // Register-file value: pointers are mirrored inside this block
  always_comb begin
    if (int'(nib) == B_IDX)       reg_val = b_q;
    else if (int'(nib) == X_IDX)  reg_val = x_q;
    else if (int'(nib) == SP_IDX) reg_val = sp_q;
    else                          reg_val = mem_rdata_i;
  end

  assign wdata = (dec.kind == OK_DECSKIP) ? (reg_val - 1'b1) : opbyte_i;

  // Operand address selection
  always_comb begin
    case (dec.mode)
      AM_B, AM_BINC, AM_BDEC: addr_o = pend_q ? paddr_q : b_q;
      AM_X, AM_XINC, AM_XDEC: addr_o = x_q;
      AM_ABS:                 addr_o = opbyte_i;
      AM_PUSH:                addr_o = sp_q;
      AM_POP:                 addr_o = sp_q + 1'b1;
      AM_REG:                 addr_o = {REG_PAGE, nib};
      default:                addr_o = '0;
    endcase
  end

  assign addr_vld_o  = fire && (dec.mode != AM_NONE);
  assign reg_wdata_o = wdata;
  assign skip_o      = fire && ((dec.kind == OK_BTEST && b_q[3:0] == nib) ||
                                (dec.kind == OK_DECSKIP && wdata == '0));
  assign b_ptr_o     = b_q;
  assign x_ptr_o     = x_q;
  assign sp_ptr_o    = sp_q;
  assign prefix_o    = pend_q;

  assert_kill_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    instr_vld_i && instr_kill_i |-> !addr_vld_o && !skip_o);

  assert_skip_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    skip_o |-> instr_vld_i && (dec.kind == OK_BTEST || dec.kind == OK_DECSKIP));

  assert_prefix_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && dec.kind == OK_PREFIX |=> prefix_o && addr_vld_o == 1'b0 ||
                                      (prefix_o && instr_vld_i));

endmodule

// File: tb/opaddr_gen_bench.sv
`timescale 1ns/100ps
module opaddr_gen_bench;

  typedef struct packed {
    logic [7:0] op;
    logic [7:0] byt;
    logic [7:0] rd;
    logic       kill;
    logic       evld;
    logic [7:0] eaddr;
    logic       eskip;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t VEC [NV] = '{
    '{8'h9F, 8'h20, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 4'd7},   // R7 B <= 0x20
    '{8'hAE, 8'h00, 8'h00, 1'b0, 1'b1, 8'h20, 1'b0, 4'd2},   // R2
    '{8'hAA, 8'h00, 8'h00, 1'b0, 1'b1, 8'h20, 1'b0, 4'd2},   // R2 B -> 21
    '{8'hA3, 8'h00, 8'h00, 1'b0, 1'b1, 8'h21, 1'b0, 4'd2},   // R2 B -> 20
    '{8'hDC, 8'h40, 8'h00, 1'b0, 1'b1, 8'hFC, 1'b0, 4'd9},   // R9 X <= 40
    '{8'hBA, 8'h00, 8'h00, 1'b0, 1'b1, 8'h40, 1'b0, 4'd3},   // R3 X -> 41
    '{8'hB3, 8'h00, 8'h00, 1'b0, 1'b1, 8'h41, 1'b0, 4'd3},   // R3 X -> 40
    '{8'hBE, 8'h00, 8'h00, 1'b0, 1'b1, 8'h40, 1'b0, 4'd3},   // R3
    '{8'h9D, 8'h33, 8'h00, 1'b0, 1'b1, 8'h33, 1'b0, 4'd4},   // R4
    '{8'hBD, 8'h55, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 4'd5},   // R5 prefix
    '{8'h80, 8'h00, 8'h00, 1'b0, 1'b1, 8'h55, 1'b0, 4'd5},   // R5 override
    '{8'h80, 8'h00, 8'h00, 1'b0, 1'b1, 8'h20, 1'b0, 4'd6},   // R6 back to B
    '{8'h67, 8'h00, 8'h00, 1'b0, 1'b1, 8'h6F, 1'b0, 4'd11},  // R11 SP -> 6E
    '{8'h8C, 8'h00, 8'h00, 1'b0, 1'b1, 8'h6F, 1'b0, 4'd11},  // R11 SP -> 6F
    '{8'h5A, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 4'd7},   // R7 B <= 5
    '{8'h45, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 4'd8},   // R8 match
    '{8'h44, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 4'd8},   // R8 mismatch
    '{8'hCE, 8'h00, 8'h00, 1'b0, 1'b1, 8'hFE, 1'b0, 4'd10},  // R10 B -> 4
    '{8'hC3, 8'h00, 8'h01, 1'b0, 1'b1, 8'hF3, 1'b1, 4'd10},  // R10 zero
    '{8'hC3, 8'h00, 8'h00, 1'b0, 1'b1, 8'hF3, 1'b0, 4'd10},  // R10 FF
    '{8'hBD, 8'h77, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 4'd5},   // R5 prefix
    '{8'h80, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 4'd13},  // R13 killed
    '{8'hAE, 8'h00, 8'h00, 1'b0, 1'b1, 8'h04, 1'b0, 4'd6},   // R6 dropped
    '{8'hBD, 8'h10, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 4'd5},   // R5 prefix
    '{8'hAA, 8'h00, 8'h00, 1'b0, 1'b1, 8'h10, 1'b0, 4'd5},   // R5 B held
    '{8'hAE, 8'h00, 8'h00, 1'b0, 1'b1, 8'h04, 1'b0, 4'd5},   // R5
    '{8'h9C, 8'h12, 8'h00, 1'b0, 1'b1, 8'h12, 1'b0, 4'd4},   // R4
    '{8'hBC, 8'h5E, 8'h00, 1'b0, 1'b1, 8'h5E, 1'b0, 4'd4},   // R4
    '{8'hA9, 8'h6A, 8'h00, 1'b0, 1'b1, 8'h6A, 1'b0, 4'd4},   // R4
    '{8'hDD, 8'h00, 8'h00, 1'b0, 1'b1, 8'hFD, 1'b0, 4'd9},   // R9 SP <= 0
    '{8'h67, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 4'd12},  // R12 SP -> FF
    '{8'h8C, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 4'd12},  // R12 SP -> 00
    '{8'hDC, 8'hFF, 8'h00, 1'b0, 1'b1, 8'hFC, 1'b0, 4'd9},   // R9 X <= FF
    '{8'hBA, 8'h00, 8'h00, 1'b0, 1'b1, 8'hFF, 1'b0, 4'd12},  // R12 X -> 00
    '{8'hBE, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 4'd12},  // R12
    '{8'h44, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 4'd13},  // R13 no skip
    '{8'h44, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 4'd8},   // R8 B still 4
    '{8'h7A, 8'h00, 8'h00, 1'b0, 1'b1, 8'h04, 1'b0, 4'd2},   // R2 bit op
    '{8'h9B, 8'h00, 8'h00, 1'b0, 1'b1, 8'h04, 1'b0, 4'd2},   // R2 B -> 3
    '{8'hAE, 8'h00, 8'h00, 1'b0, 1'b1, 8'h03, 1'b0, 4'd2},   // R2
    '{8'hCC, 8'h00, 8'h00, 1'b0, 1'b1, 8'hFC, 1'b0, 4'd10},  // R10 X -> FF
    '{8'hBE, 8'h00, 8'h00, 1'b0, 1'b1, 8'hFF, 1'b0, 4'd10}   // R10
  };

  logic       clk;
  logic       rst_n;
  logic       instr_vld_i;
  logic       instr_kill_i;
  logic [7:0] opcode_i;
  logic [7:0] opbyte_i;
  logic [7:0] mem_rdata_i;
  logic [7:0] addr_o;
  logic       addr_vld_o;
  logic [7:0] reg_wdata_o;
  logic [7:0] b_ptr_o;
  logic [7:0] x_ptr_o;
  logic [7:0] sp_ptr_o;
  logic       prefix_o;
  logic       skip_o;

  int n_chk;
  int n_fail;
  bit done;

  opaddr_gen u_opaddr_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_vld_i  (instr_vld_i),
    .instr_kill_i (instr_kill_i),
    .opcode_i     (opcode_i),
    .opbyte_i     (opbyte_i),
    .mem_rdata_i  (mem_rdata_i),
    .addr_o       (addr_o),
    .addr_vld_o   (addr_vld_o),
    .reg_wdata_o  (reg_wdata_o),
    .b_ptr_o      (b_ptr_o),
    .x_ptr_o      (x_ptr_o),
    .sp_ptr_o     (sp_ptr_o),
    .prefix_o     (prefix_o),
    .skip_o       (skip_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op, input logic [7:0] byt,
                       input logic [7:0] rd, input logic kill);
    @(negedge clk);
    instr_vld_i  = 1'b1;
    instr_kill_i = kill;
    opcode_i     = op;
    opbyte_i     = byt;
    mem_rdata_i  = rd;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    instr_vld_i  = 1'b0;
    instr_kill_i = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic reset_checks();
    check("R1 b", b_ptr_o, 8'h00);
    check("R1 x", x_ptr_o, 8'h00);
    check("R1 sp", sp_ptr_o, 8'h6F);
    check("R1 prefix", {7'd0, prefix_o}, 8'h00);
    check("R1 addr_vld", {7'd0, addr_vld_o}, 8'h00);
    check("R1 skip", {7'd0, skip_o}, 8'h00);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    instr_vld_i = 1'b0; instr_kill_i = 1'b0;
    opcode_i = 8'h00; opbyte_i = 8'h00; mem_rdata_i = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    reset_checks();  // R1

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].op, VEC[i].byt, VEC[i].rd, VEC[i].kill);
      check($sformatf("R%0d vec%0d addr_vld", VEC[i].req, i),
            {7'd0, addr_vld_o}, {7'd0, VEC[i].evld});
      if (VEC[i].evld)
        check($sformatf("R%0d vec%0d addr", VEC[i].req, i), addr_o, VEC[i].eaddr);
      check($sformatf("R%0d vec%0d skip", VEC[i].req, i),
            {7'd0, skip_o}, {7'd0, VEC[i].eskip});
    end
    idle();
    check("R2 final b", b_ptr_o, 8'h03);
    check("R10 final x", x_ptr_o, 8'hFF);
    check("R12 final sp", sp_ptr_o, 8'h00);

    // R9 write-back of immediate
    issue(8'hD5, 8'hA5, 8'h00, 1'b0);
    check("R9 wdata", reg_wdata_o, 8'hA5);
    check("R9 addr", addr_o, 8'hF5);
    // R10 decrement of B through register form
    issue(8'hCE, 8'h00, 8'h99, 1'b0);
    check("R10 wdata", reg_wdata_o, 8'h02);
    idle();
    check("R10 b updated", b_ptr_o, 8'h02);

    // R5 / R6 prefix flag visibility
    issue(8'hBD, 8'h3C, 8'h00, 1'b0);
    check("R5 prefix not yet", {7'd0, prefix_o}, 8'h00);
    idle();
    check("R5 prefix raised", {7'd0, prefix_o}, 8'h01);
    idle();
    check("R5 prefix held while idle", {7'd0, prefix_o}, 8'h01);
    issue(8'hB8, 8'h00, 8'h00, 1'b0);  // non-pointer instruction consumes it
    idle();
    check("R6 prefix cleared", {7'd0, prefix_o}, 8'h00);
    issue(8'hAB, 8'h00, 8'h00, 1'b0);
    check("R6 uses B", addr_o, 8'h02);
    idle();
    check("R2 B decremented", b_ptr_o, 8'h01);

    // R7 load with k = 0 gives 15; R8 compare on that value
    issue(8'h50, 8'h00, 8'h00, 1'b0);
    check("R7 no addr", {7'd0, addr_vld_o}, 8'h00);
    idle();
    check("R7 b=15-0", b_ptr_o, 8'h0F);
    issue(8'h4F, 8'h00, 8'h00, 1'b0);
    check("R8 skip k=F", {7'd0, skip_o}, 8'h01);
    // R13 killed pointer step leaves B
    issue(8'hAA, 8'h00, 8'h00, 1'b1);
    idle();
    check("R13 b kept", b_ptr_o, 8'h0F);

    // Mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    reset_checks();  // R1
    rst_n = 1'b1;
    idle();
    finish_run();
  end

endmodule